// File: doc/BRIEF.md
# Partial Timestamp Reconstruction Unit

A capture path sometimes keeps only a compact 32-bit word per event: the two least significant bits of the seconds count and the full 30-bit nanoseconds count. This block turns such a word back into a full 32-bit seconds and 30-bit nanoseconds timestamp. It does so by reading the free-running local time counter some time after the event and using that later seconds value as a reference. The reconstructed seconds value is the latest value not greater than the reference whose two low bits match the captured ones. A capture therefore resolves correctly if it lies up to three whole seconds before the reference.

The capture arrives either as the packed 32-bit word or as two separate fields, selected per request. The result appears one cycle after the request and is flagged by a valid strobe. Alongside the result, the block forwards the capture word to the downstream path. When that word has been consumed, it is zeroed so that the downstream path does not see the timestamp bits.

Top module: `ts_rebuild`

## Requirements
- R1: In packed mode (`in_use_raw`=1), bits 31:30 of `in_raw` are the captured seconds bits [1:0] and bits 29:0 are the captured nanoseconds.
- R2: In split mode (`in_use_raw`=0), the captured seconds bits come from `in_lo_sec` and the nanoseconds from `in_nsec`, and `in_raw` does not affect the result.
- R3: `out_nsec` equals the captured nanoseconds field unchanged.
- R4: When `ref_sec[1:0]` is greater than or equal to the captured seconds bits, `out_sec` is `ref_sec` with bits 1:0 replaced by the captured bits.
- R5: When `ref_sec[1:0]` is less than the captured seconds bits, 4 is first subtracted from `ref_sec`, and bits 1:0 of that result are then replaced by the captured bits.
- R6: The subtraction wraps modulo 2^32, so a borrow from a reference below 4 yields a result near 0xFFFFFFFF.
- R7: `out_valid` is high in exactly the cycle after the cycle in which `in_valid` was sampled high.
- R8: `out_word` registers, every cycle, zero if a packed capture was consumed that cycle (`in_valid`=1 and `in_use_raw`=1); otherwise it registers `in_raw` unchanged.
- R9: After reset, `out_valid`, `out_sec`, `out_nsec` and `out_word` are all zero.
- R10: While `in_valid` is low, `out_sec` and `out_nsec` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Reconstruction request |
| in_use_raw | input | 1 | 1: use packed word, 0: use split fields |
| in_raw | input | 32 | Packed capture word |
| in_lo_sec | input | 2 | Split-mode captured seconds bits |
| in_nsec | input | 30 | Split-mode captured nanoseconds |
| ref_sec | input | 32 | Seconds read from the local counter after the capture |
| out_valid | output | 1 | Result valid |
| out_sec | output | 32 | Reconstructed seconds |
| out_nsec | output | 30 | Reconstructed nanoseconds |
| out_word | output | 32 | Forwarded capture word, zeroed once consumed |

## Verification
The bench covers references whose low bits are equal to, above and below the captured bits. If the borrow test were off by one, the result would be four seconds late or early. It drives a borrow from a reference below 4 to catch a design that saturates instead of wrapping. It also alternates packed and split requests with disagreeing `in_raw`, so a swapped field slice or a wrong mode selection shows up as wrong low seconds bits or wrong nanoseconds. Idle cycles check that results hold and that the forwarded word is zeroed only for consumed packed captures.

// File: rtl/ts_rebuild.sv
module ts_rebuild #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30,
  parameter int LOW_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_use_raw,
  input  logic [LOW_W+NS_W-1:0] in_raw,
  input  logic [LOW_W-1:0]      in_lo_sec,
  input  logic [NS_W-1:0]       in_nsec,
  input  logic [SEC_W-1:0]      ref_sec,
  output logic                  out_valid,
  output logic [SEC_W-1:0]      out_sec,
  output logic [NS_W-1:0]       out_nsec,
  output logic [LOW_W+NS_W-1:0] out_word
);
  localparam int RAW_W = LOW_W + NS_W;
  localparam logic [SEC_W-1:0] STEP = SEC_W'(1) << LOW_W;

  logic [LOW_W-1:0] cap_lo;
  logic [NS_W-1:0]  cap_ns;
  logic             borrow;
  logic [SEC_W-1:0] base;
  logic [SEC_W-1:0] sec_full;

  assign cap_lo   = in_use_raw ? in_raw[RAW_W-1:NS_W] : in_lo_sec;
  assign cap_ns   = in_use_raw ? in_raw[NS_W-1:0]     : in_nsec;
  assign borrow   = ref_sec[LOW_W-1:0] < cap_lo;
  assign base     = borrow ? ref_sec - STEP : ref_sec;
  assign sec_full = {base[SEC_W-1:LOW_W], cap_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sec   <= '0;
      out_nsec  <= '0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      out_word  <= (in_valid && in_use_raw) ? '0 : in_raw;
      if (in_valid) begin
        out_sec  <= sec_full;
        out_nsec <= cap_ns;
      end
    end
  end
endmodule

// File: rtl/ts_rebuild_chk.sv
module ts_rebuild_chk #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30,
  parameter int LOW_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_use_raw,
  input logic [LOW_W+NS_W-1:0] in_raw,
  input logic [LOW_W-1:0]      in_lo_sec,
  input logic [NS_W-1:0]       in_nsec,
  input logic [SEC_W-1:0]      ref_sec,
  input logic                  out_valid,
  input logic [SEC_W-1:0]      out_sec,
  input logic [NS_W-1:0]       out_nsec,
  input logic [LOW_W+NS_W-1:0] out_word
);
  localparam int RAW_W = LOW_W + NS_W;
  localparam logic [SEC_W-1:0] SPAN = (SEC_W'(1) << LOW_W) - SEC_W'(1);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_PACKED_NSEC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_use_raw) |=> out_nsec == $past(in_raw[NS_W-1:0])); // R1
  AST_SPLIT_NSEC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_use_raw) |=> out_nsec == $past(in_nsec)); // R2
  AST_PACKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_use_raw) |=> out_sec[LOW_W-1:0] == $past(in_raw[RAW_W-1:NS_W])); // R4
  AST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (SEC_W'($past(ref_sec) - out_sec) <= SPAN)); // R5
  AST_SCRUB: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_use_raw) |=> out_word == '0); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_sec) && $stable(out_nsec))); // R10
endmodule

bind ts_rebuild ts_rebuild_chk #(.SEC_W(SEC_W), .NS_W(NS_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_use_raw(in_use_raw),
  .in_raw(in_raw), .in_lo_sec(in_lo_sec), .in_nsec(in_nsec), .ref_sec(ref_sec),
  .out_valid(out_valid), .out_sec(out_sec), .out_nsec(out_nsec), .out_word(out_word)
);

// File: tb/ts_rebuild_tb.sv
`timescale 1ns/1ps
module ts_rebuild_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_use_raw = 0;
  logic [31:0] in_raw = 0, ref_sec = 0;
  logic [1:0]  in_lo_sec = 0;
  logic [29:0] in_nsec = 0;
  logic        out_valid;
  logic [31:0] out_sec, out_word;
  logic [29:0] out_nsec;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic        e_valid = 0;
  logic [31:0] e_sec = 0, e_word = 0;
  logic [29:0] e_ns = 0;
  string       sec_tag = "R4";

  always #2 clk = ~clk;

  ts_rebuild u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_use_raw(in_use_raw),
    .in_raw(in_raw), .in_lo_sec(in_lo_sec), .in_nsec(in_nsec), .ref_sec(ref_sec),
    .out_valid(out_valid), .out_sec(out_sec), .out_nsec(out_nsec), .out_word(out_word));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R7 out_valid", {31'd0, out_valid}, {31'd0, e_valid});
    chk("R3 out_nsec", {2'd0, out_nsec}, {2'd0, e_ns});
    chk(sec_tag, out_sec, e_sec);
    chk("R8 out_word", out_word, e_word);
  endtask

  task automatic step(input bit v, input bit use_raw, input logic [31:0] raw,
                      input logic [1:0] lo, input logic [29:0] ns, input logic [31:0] rs);
    logic [1:0]  c;
    logic [31:0] back;
    @(negedge clk);
    compare_all();
    in_valid = v; in_use_raw = use_raw; in_raw = raw;
    in_lo_sec = lo; in_nsec = ns; ref_sec = rs;
    c = use_raw ? raw[31:30] : lo;
    e_valid = v;
    e_word = (v && use_raw) ? 32'd0 : raw;
    if (v) begin
      back = {30'd0, rs[1:0] - c};
      e_sec = rs - back;
      e_ns = use_raw ? raw[29:0] : ns;
      if (rs < 32'd4 && rs[1:0] < c) sec_tag = "R6 out_sec";
      else if (rs[1:0] < c)          sec_tag = "R5 out_sec";
      else                           sec_tag = use_raw ? "R1/R4 out_sec" : "R2/R4 out_sec";
    end else sec_tag = "R10 out_sec";
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all();                       // R9 reset state
    rst_n = 1;
    step(1, 1, {2'd0, 30'h0ABC_DEF0}, 0, 0, 32'h10);      // R4 equal bits: 0x10
    step(1, 1, {2'd3, 30'h1234_5678}, 0, 0, 32'h11);      // R5 borrow: 0x0F
    step(1, 1, {2'd1, 30'h3FFF_FFFF}, 0, 0, 32'h0);       // R6 wrap: 0xFFFFFFFD
    step(1, 1, {2'd2, 30'h0}, 0, 0, 32'h2);               // R4 equal: 2
    step(1, 1, {2'd0, 30'h1}, 0, 0, 32'hFFFF_FFFF);       // R4: 0xFFFFFFFC
    step(1, 0, 32'hFFFF_FFFF, 2'd3, 30'h2AAA_AAAA, 32'h104); // R2 split: 0x103
    step(0, 1, 32'hDEAD_BEEF, 2'd1, 30'h5, 32'h7);        // R10 hold, R8 passthrough
    step(0, 0, 32'h1234_5678, 2'd0, 30'h0, 32'h0);        // R10 hold
    step(1, 0, 32'hCAFE_F00D, 2'd2, 30'h1, 32'h1);        // R6 split wrap: 0xFFFFFFFE
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom(),
           2'($urandom()), 30'($urandom()),
           ($urandom_range(0, 7) == 0) ? 32'($urandom_range(0, 5)) : $urandom());
    step(0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule